// File: doc/BRIEF.md
# Processor Debug Register Interface

This block is the responding side of a small register-access port through which an external debug requester controls a 64-bit processor core and inspects its state. The requester presents a 4-bit register address, 64-bit write data, a write flag and a request strobe. It holds the strobe until the block answers with a one-cycle acknowledge. On a read, the data is carried on the read-data port in that same cycle.

Writes to the control register halt the core, let it run freely again, or let a halted core retire exactly one instruction. A status register reports whether the core is currently stopped. Read-only registers return the next instruction address, the machine state, the condition register and a packed word of fixed-point exception flags. The general registers are reached indirectly: the requester first writes an index register, then reads a data register that returns the selected general register. The core itself sits outside the block. It takes the halt and step outputs, pulses a retire input when an instruction completes, and supplies its state on plain inputs.

Top module: `dbg_regif`

## Requirements
- R1: A request sampled at a rising edge while the port is idle produces `ack_o` high for exactly one cycle, in the cycle after that edge. No further acknowledge is given until `req_i` has been seen low.
- R2: For a read, `rdata_o` carries the addressed value in the acknowledge cycle. `rdata_o` is zero in every other cycle and on write acknowledges.
- R3: A write to address 0 with bit 0 set halts the core: `core_halt_o` goes high, and a read of address 1 returns 2, meaning bit 1 is the stopped flag.
- R4: A write to address 0 with bit 1 set and bit 0 clear resumes the core: `core_halt_o` and `core_step_o` go low and the stopped flag reads 0. When bits 0 and 1 are both set, halting wins.
- R5: A write to address 0 with bit 3 set while the core is stopped raises `core_step_o` and lowers `core_halt_o`, and the stopped flag reads 0. The first cycle with `core_retire_i` high ends the step: `core_step_o` falls, and `core_halt_o` and the stopped flag return high. A step write while the core runs has no effect.
- R6: Reads of address 2 return `core_nia_i`, reads of address 3 return `core_msr_i`, and reads of address 8 return `core_cr_i`.
- R7: A write to address 4 loads the general-register index from the low 5 bits of the write data; higher bits are dropped. The index drives `gpr_sel_o`. A read of address 5 returns `gpr_data_i` for that index.
- R8: A read of address 9 returns the exception flags packed as SO in bit 0, CA in bit 2, CA32 in bit 3, OV in bit 4 and OV32 in bit 5. All other bits are zero.
- R9: Reads of addresses 0, 4, 6, 7 and 10 to 15 return zero. Writes to any address other than 0 and 4 change neither the run state nor the index.
- R10: After reset, `ack_o`, `rdata_o`, `core_halt_o`, `core_step_o` and `gpr_sel_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, held until acknowledged |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 64 | Write data |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 64 | Read data, valid with acknowledge |
| core_halt_o | output | 1 | Core must stay stopped |
| core_step_o | output | 1 | Core may retire one instruction |
| core_retire_i | input | 1 | Core retired an instruction |
| core_nia_i | input | 64 | Next instruction address |
| core_msr_i | input | 64 | Machine state |
| core_cr_i | input | 64 | Condition register |
| core_xflags_i | input | 5 | {OV32, OV, CA32, CA, SO} |
| gpr_sel_o | output | 5 | Selected general register |
| gpr_data_i | input | 64 | Value of the selected general register |

## Verification
The bench builds the block with its default 64-bit data path and 32 general registers. At that size, index 31 is the highest legal value, and a write of 0x25 shows the dropped upper bit landing on index 5. The full 64-bit width makes the packed flag word, and the zero in every bit outside it, visible at the port. The stub core's register file is addressable in full, so the index/data pair is exercised at both ends of its range.

// File: rtl/dbg_regif_pkg.sv
package dbg_regif_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned XFLAG_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_STAT  = 4'd1,
        RA_NIA   = 4'd2,
        RA_MSR   = 4'd3,
        RA_GIDX  = 4'd4,
        RA_GDAT  = 4'd5,
        RA_CR    = 4'd8,
        RA_XFLG  = 4'd9
    } reg_addr_e;

    // control word command bits
    localparam int unsigned CMD_HALT_BIT = 0;
    localparam int unsigned CMD_RUN_BIT  = 1;
    localparam int unsigned CMD_STEP_BIT = 3;

    // status word
    localparam int unsigned STS_STOPPED_BIT = 1;

    // packed exception flag positions, indexed by core_xflags_i bit
    localparam int unsigned XF_POS_SO   = 0;
    localparam int unsigned XF_POS_CA   = 2;
    localparam int unsigned XF_POS_CA32 = 3;
    localparam int unsigned XF_POS_OV   = 4;
    localparam int unsigned XF_POS_OV32 = 5;

endpackage

// File: rtl/dbg_handshake.sv
module dbg_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic ack_o
);
    typedef struct packed {
        logic ack;
        logic hold;
    } hs_t;

    hs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        accept_o  = req_i & ~st_q.ack & ~st_q.hold;
        st_d.ack  = accept_o;
        // after the acknowledge, wait until the request is dropped
        st_d.hold = (st_q.ack | st_q.hold) & req_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o = st_q.ack;

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_regif_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic              retire_i,
    output logic              halt_o,
    output logic              step_o,
    output logic              stopped_o
);
    typedef struct packed {
        logic halted;
        logic stepping;
    } run_t;

    run_t rs_d, rs_q;
    logic c_halt, c_run, c_step, stopped_now;

    always_comb begin
        rs_d        = rs_q;
        c_halt      = cmd_we_i & cmd_i[CMD_HALT_BIT];
        c_run       = cmd_we_i & cmd_i[CMD_RUN_BIT] & ~c_halt;
        c_step      = cmd_we_i & cmd_i[CMD_STEP_BIT];
        stopped_now = rs_q.halted & ~rs_q.stepping;

        if (rs_q.stepping && retire_i) begin
            rs_d.stepping = 1'b0;
        end

        if (c_halt) begin
            rs_d.halted = 1'b1;
        end else if (c_run) begin
            rs_d.halted   = 1'b0;
            rs_d.stepping = 1'b0;
        end

        if (c_step && stopped_now && !c_run) begin
            rs_d.stepping = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign halt_o    = rs_q.halted & ~rs_q.stepping;
    assign step_o    = rs_q.stepping;
    assign stopped_o = rs_q.halted & ~rs_q.stepping;

endmodule

// File: rtl/dbg_rdmux.sv
module dbg_rdmux
    import dbg_regif_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               stopped_i,
    input  logic [DATA_W-1:0]  nia_i,
    input  logic [DATA_W-1:0]  msr_i,
    input  logic [DATA_W-1:0]  cr_i,
    input  logic [DATA_W-1:0]  gpr_i,
    input  logic [XFLAG_W-1:0] xflags_i,
    output logic [DATA_W-1:0]  data_o
);
    localparam int unsigned XPOS [XFLAG_W] = '{XF_POS_SO, XF_POS_CA, XF_POS_CA32,
                                               XF_POS_OV, XF_POS_OV32};

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] xpack_w;

    always_comb begin
        status_w                  = '0;
        status_w[STS_STOPPED_BIT] = stopped_i;
    end

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_xbit
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < XFLAG_W; k++) begin
                    if (XPOS[k] == g) hit = xflags_i[k];
                end
            end
            assign xpack_w[g] = hit;
        end
    endgenerate

    always_comb begin
        unique case (addr_i)
            RA_STAT: data_o = status_w;
            RA_NIA:  data_o = nia_i;
            RA_MSR:  data_o = msr_i;
            RA_GDAT: data_o = gpr_i;
            RA_CR:   data_o = cr_i;
            RA_XFLG: data_o = xpack_w;
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/dbg_regif.sv
module dbg_regif
    import dbg_regif_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned GPR_NUM = 32,
    localparam int unsigned IDX_W  = $clog2(GPR_NUM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic               ack_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               core_halt_o,
    output logic               core_step_o,
    input  logic               core_retire_i,
    input  logic [DATA_W-1:0]  core_nia_i,
    input  logic [DATA_W-1:0]  core_msr_i,
    input  logic [DATA_W-1:0]  core_cr_i,
    input  logic [XFLAG_W-1:0] core_xflags_i,
    output logic [IDX_W-1:0]   gpr_sel_o,
    input  logic [DATA_W-1:0]  gpr_data_i
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t              tq_d, tq_q;
    logic              accept;
    logic              ctl_we;
    logic              stopped;
    logic [DATA_W-1:0] mux_data;

    dbg_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .accept_o (accept),
        .ack_o    (ack_o)
    );

    assign ctl_we = accept & wr_i & (addr_i == RA_CTRL);

    dbg_runctl #(.DATA_W(DATA_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we_i  (ctl_we),
        .cmd_i     (wdata_i),
        .retire_i  (core_retire_i),
        .halt_o    (core_halt_o),
        .step_o    (core_step_o),
        .stopped_o (stopped)
    );

    dbg_rdmux #(.DATA_W(DATA_W)) u_mux (
        .addr_i    (addr_i),
        .stopped_i (stopped),
        .nia_i     (core_nia_i),
        .msr_i     (core_msr_i),
        .cr_i      (core_cr_i),
        .gpr_i     (gpr_data_i),
        .xflags_i  (core_xflags_i),
        .data_o    (mux_data)
    );

    always_comb begin
        tq_d       = tq_q;
        tq_d.rdata = '0;
        if (accept && !wr_i) begin
            tq_d.rdata = mux_data;
        end
        if (accept && wr_i && (addr_i == RA_GIDX)) begin
            tq_d.idx = wdata_i[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq_q <= '0;
        end else begin
            tq_q <= tq_d;
        end
    end

    assign rdata_o   = tq_q.rdata;
    assign gpr_sel_o = tq_q.idx;

endmodule

// File: rtl/dbg_regif_chk.sv
module dbg_regif_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              ack_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              core_halt_o,
    input logic              core_step_o,
    input logic              core_retire_i,
    input logic [IDX_W-1:0]  gpr_sel_o
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);                                              // R1
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(req_i));                                 // R1
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (rdata_o == '0));                                    // R2
    AST_STEP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        core_step_o |-> !core_halt_o);                                  // R5
    AST_STEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_step_o && core_retire_i) |=> (!core_step_o && core_halt_o)); // R5
    AST_SEL_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpr_sel_o) |-> ack_o);                                 // R7
endmodule

bind dbg_regif dbg_regif_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .ack_o         (ack_o),
    .rdata_o       (rdata_o),
    .core_halt_o   (core_halt_o),
    .core_step_o   (core_step_o),
    .core_retire_i (core_retire_i),
    .gpr_sel_o     (gpr_sel_o)
);

// File: tb/dbg_regif_tb_top.sv
module dbg_regif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;

    localparam logic [DW-1:0] NIA_V = 64'h0000_0000_0001_0A40;
    localparam logic [DW-1:0] MSR_V = 64'h8000_0000_0000_1033;
    localparam logic [DW-1:0] CR_V  = 64'h0000_0000_4822_0084;
    // {OV32,OV,CA32,CA,SO} = 1,0,1,0,1 -> bits 5,3,0 -> 0x29
    localparam logic [4:0]    XF_V  = 5'b10101;

    function automatic logic [DW-1:0] gpr_val(input logic [4:0] i);
        return 64'h6E00_0000_0000_0000 | (64'(i) * 64'h0101_0101);
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, wr = 1'b0, retire = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ack, halt, step;
    logic [DW-1:0] rdata, gdat;
    logic [4:0]    gsel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign gdat = gpr_val(gsel);

    dbg_regif dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
        .core_halt_o(halt), .core_step_o(step), .core_retire_i(retire),
        .core_nia_i(NIA_V), .core_msr_i(MSR_V), .core_cr_i(CR_V),
        .core_xflags_i(XF_V), .gpr_sel_o(gsel), .gpr_data_i(gdat)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one access; ack is expected in the cycle after the request is sampled
    task automatic xfer(input logic w, input logic [3:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        chk(ack === 1'b1, "R1 ack one cycle after request", 64'(ack), 64'd1);
        rd = rdata;
        req = 1'b0;
        @(negedge clk);
        chk(ack === 1'b0, "R1 ack single pulse", 64'(ack), 64'd0);
        chk(rdata === '0, "R2 rdata zero outside ack", rdata, '0);
    endtask

    typedef struct packed {
        logic          w;
        logic [3:0]    a;
        logic [DW-1:0] d;
        logic [DW-1:0] e;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd4, 64'd7,  64'd0},                 // R7 index 7, R2 write ack data 0
        '{1'b0, 4'd5, 64'd0,  gpr_val(5'd7)},         // R7
        '{1'b0, 4'd2, 64'd0,  NIA_V},                 // R6
        '{1'b0, 4'd3, 64'd0,  MSR_V},                 // R6
        '{1'b0, 4'd8, 64'd0,  CR_V},                  // R6
        '{1'b0, 4'd9, 64'd0,  64'h29},                // R8
        '{1'b0, 4'd1, 64'd0,  64'd0},                 // R3 running -> not stopped
        '{1'b0, 4'd6, 64'd0,  64'd0},                 // R9
        '{1'b0, 4'd0, 64'd0,  64'd0},                 // R9
        '{1'b0, 4'd15, 64'd0, 64'd0},                 // R9
        '{1'b1, 4'd4, 64'd31, 64'd0},                 // R7 highest index
        '{1'b0, 4'd5, 64'd0,  gpr_val(5'd31)},        // R7
        '{1'b1, 4'd4, 64'h25, 64'd0},                 // R7 upper bit dropped
        '{1'b0, 4'd5, 64'd0,  gpr_val(5'd5)}          // R7
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        chk(ack === 1'b0 && rdata === '0, "R10 reset ack/rdata", rdata, '0);
        chk(halt === 1'b0 && step === 1'b0, "R10 reset run state", {halt, step}, '0);
        chk(gsel === 5'd0, "R10 reset index", 64'(gsel), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].w, VECS[i].a, VECS[i].d, rd);
            chk(rd === VECS[i].e, $sformatf("R2 R6 R7 R8 R9 vector %0d", i), rd, VECS[i].e);
        end
        chk(gsel === 5'd5, "R7 gpr_sel_o", 64'(gsel), 64'd5);

        // R1: request held long after the acknowledge
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 4'd2;
        @(negedge clk);
        chk(ack === 1'b1 && rdata === NIA_V, "R1 held request first ack", rdata, NIA_V);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(ack === 1'b0, "R1 no second ack while held", 64'(ack), 64'd0);
        end
        req = 1'b0;
        @(negedge clk);

        // R5: step while running is ignored
        xfer(1'b1, 4'd0, 64'h8, rd);
        chk(step === 1'b0 && halt === 1'b0, "R5 step while running ignored", {halt, step}, '0);

        // R3: halt
        xfer(1'b1, 4'd0, 64'h1, rd);
        chk(halt === 1'b1 && step === 1'b0, "R3 halt asserted", {halt, step}, 64'd2);
        xfer(1'b0, 4'd1, 64'd0, rd);
        chk(rd === 64'd2, "R3 status stopped", rd, 64'd2);

        // R9: writes to other addresses leave state alone
        xfer(1'b1, 4'd1, '1, rd);
        xfer(1'b1, 4'd5, '1, rd);
        xfer(1'b1, 4'd12, '1, rd);
        chk(halt === 1'b1 && gsel === 5'd5, "R9 ignored writes", {halt, 3'b0, gsel}, 64'h105);

        // R5: single step
        xfer(1'b1, 4'd0, 64'h8, rd);
        chk(step === 1'b1 && halt === 1'b0, "R5 stepping", {halt, step}, 64'd1);
        xfer(1'b0, 4'd1, 64'd0, rd);
        chk(rd === 64'd0, "R5 stopped flag clear during step", rd, 64'd0);
        @(negedge clk); retire = 1'b1;
        @(negedge clk); retire = 1'b0;
        chk(step === 1'b0 && halt === 1'b1, "R5 step ends on retire", {halt, step}, 64'd2);
        xfer(1'b0, 4'd1, 64'd0, rd);
        chk(rd === 64'd2, "R5 stopped again", rd, 64'd2);

        // R4: resume, then halt+resume together
        xfer(1'b1, 4'd0, 64'h2, rd);
        chk(halt === 1'b0 && step === 1'b0, "R4 resumed", {halt, step}, '0);
        xfer(1'b0, 4'd1, 64'd0, rd);
        chk(rd === 64'd0, "R4 status running", rd, 64'd0);
        xfer(1'b1, 4'd0, 64'h3, rd);
        chk(halt === 1'b1, "R4 halt wins over resume", 64'(halt), 64'd1);

        // R4: resume during a step cancels it
        xfer(1'b1, 4'd0, 64'h8, rd);
        xfer(1'b1, 4'd0, 64'h2, rd);
        chk(halt === 1'b0 && step === 1'b0, "R4 resume cancels step", {halt, step}, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule